// File: doc/BRIEF.md
# Indirect Auxiliary Command Register

This block sits behind one write-only byte port of a bus talker/listener controller. Each byte the host writes is split in two. The upper three bits form a control code, which picks the action. The lower five bits form a payload, which is either a command number or data for a hidden register.

One control code fires one-shot commands: power-on release, chip reset and finish handshake. The other defined codes load one of three hidden configuration registers:
- a clock divider count;
- the parallel poll configuration;
- a handshake and poll option register.

The block drives the parallel poll response line from the stored configuration and the local status input. It also keeps a byte of sticky interrupt status that clears when it is read.

Chip reset puts the device into a held state that lasts until the power-on release command. While the device is held, it gives no poll response, but every hidden register keeps its value and still accepts writes.

Top module: `aux_cmd_port`

## Requirements
- R1: A write with `wr_en` high is decoded on the rising clock edge. `wr_data[7:5]` is the control code and `wr_data[4:0]` is the payload. Control codes 3'b010, 3'b100, 3'b110 and 3'b111 change no output and no stored state.
- R2: Control code 3'b000 with payload 5'h02 raises `crst_pulse` for exactly the one cycle after the write and sets `held_reset`.
- R3: Control code 3'b000 with payload 5'h00 raises `pon_pulse` for exactly the one cycle after the write and clears `held_reset`.
- R4: Control code 3'b000 with payload 5'h03 raises `fh_pulse` for the one cycle after the write. Any other payload under control code 3'b000 raises no pulse and leaves `held_reset` unchanged.
- R5: Control code 3'b001 loads `clk_div` from `wr_data[3:0]`. `wr_data[4]` is ignored.
- R6: Control code 3'b011 loads the poll configuration:
  - `wr_data[4]` goes to `pp_unconf`;
  - `wr_data[3]` goes to `pp_sense`;
  - `wr_data[2:0]` goes to `pp_line`.
- R7: Control code 3'b101 loads `auxb` from `wr_data[4:0]`. `fast_src_hs` always equals `auxb[2]`.
- R8: `pp_resp` is the one-hot value `1 << pp_line` when all of the following hold:
  - `ppoll_req` is high;
  - `pp_unconf` is 0;
  - `held_reset` is 0;
  - `local_ist` equals `pp_sense`. A sense of 1 responds to a true status and a sense of 0 responds to a false status.

  Otherwise `pp_resp` is zero. The value is combinational from the inputs and the stored state.
- R9: Entering or leaving `held_reset` does not alter `clk_div`, the poll configuration or `auxb`. Loads issued while held take effect.
- R10: A status bit sets on any edge where its `evt_in` bit is high. `rd_data` shows the current status bits. An edge with `rd_en` high clears every bit except those whose `evt_in` bit is high on that same edge.
- R11: While `rst_n` is low:
  - `held_reset` is 1;
  - all pulses are 0;
  - `clk_div`, the poll configuration, `auxb` and the status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the command byte |
| wr_data | input | 8 | Command byte: control code and payload |
| rd_en | input | 1 | Status read; clears the status on the edge |
| evt_in | input | 8 | Status event inputs |
| rd_data | output | 8 | Current status bits |
| ppoll_req | input | 1 | Controller is conducting a parallel poll |
| local_ist | input | 1 | Local individual status |
| pon_pulse | output | 1 | Power-on release command strobe |
| crst_pulse | output | 1 | Chip reset command strobe |
| fh_pulse | output | 1 | Finish handshake command strobe |
| held_reset | output | 1 | Device held in reset |
| clk_div | output | 4 | Clock divider count |
| pp_unconf | output | 1 | Poll response disabled |
| pp_sense | output | 1 | Poll status sense |
| pp_line | output | 3 | Poll response line number |
| auxb | output | 5 | Handshake and poll option bits |
| fast_src_hs | output | 1 | High-speed source handshake timing select |
| pp_resp | output | 8 | Parallel poll response lines |

## Verification
The bench goes after the following corner cases:
- Undefined control codes. A decoder that treats only the top bit as a selector would load a hidden register.
- Unassigned command numbers under the immediate code. A partial compare would fire a stray pulse.
- A read that lands on the same edge as a new event. A design that lets the clear win would lose that event.
- Sense polarity and the held state in the poll response. An inverted sense, or a response while held, would drive a wrong data line.
- Hidden register values across a chip reset and power-on release. A design that reset them on entry to the held state would lose the configuration.

// File: rtl/aux_cmd_pkg.sv
package aux_cmd_pkg;
  localparam int CTRL_W = 3;
  localparam int CODE_W = 5;
  localparam int BYTE_W = CTRL_W + CODE_W;

  typedef enum logic [CTRL_W-1:0] {
    CC_EXEC = 3'b000,
    CC_ICR  = 3'b001,
    CC_PPR  = 3'b011,
    CC_AUXB = 3'b101
  } ctrl_code_e;

  localparam logic [CODE_W-1:0] OP_PON  = 5'h00;
  localparam logic [CODE_W-1:0] OP_CRST = 5'h02;
  localparam logic [CODE_W-1:0] OP_FH   = 5'h03;

  typedef struct packed {
    logic       unconf;
    logic       sense;
    logic [2:0] line;
  } ppr_t;
endpackage

// File: rtl/aux_decode.sv
module aux_decode
  import aux_cmd_pkg::*;
(
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic              ld_icr,
  output logic              ld_ppr,
  output logic              ld_auxb,
  output logic              op_pon,
  output logic              op_crst,
  output logic              op_fh,
  output logic [CODE_W-1:0] payload
);
  logic [CTRL_W-1:0] ctrl;
  logic              exec;

  assign ctrl    = wr_byte[BYTE_W-1:CODE_W];
  assign payload = wr_byte[CODE_W-1:0];

  always_comb begin
    ld_icr  = 1'b0;
    ld_ppr  = 1'b0;
    ld_auxb = 1'b0;
    exec    = 1'b0;
    if (wr_en) begin
      case (ctrl)
        CC_EXEC: exec    = 1'b1;
        CC_ICR:  ld_icr  = 1'b1;
        CC_PPR:  ld_ppr  = 1'b1;
        CC_AUXB: ld_auxb = 1'b1;
        default: ;
      endcase
    end
  end

  assign op_pon  = exec && (payload == OP_PON);
  assign op_crst = exec && (payload == OP_CRST);
  assign op_fh   = exec && (payload == OP_FH);
endmodule

// File: rtl/aux_hidden_regs.sv
module aux_hidden_regs
  import aux_cmd_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_icr,
  input  logic              ld_ppr,
  input  logic              ld_auxb,
  input  logic              op_pon,
  input  logic              op_crst,
  input  logic              op_fh,
  input  logic [CODE_W-1:0] payload,
  output logic [DIV_W-1:0]  icr_q,
  output ppr_t              ppr_q,
  output logic [CODE_W-1:0] auxb_q,
  output logic              held_q,
  output logic              pon_q,
  output logic              crst_q,
  output logic              fh_q
);
  logic [DIV_W-1:0]  icr_d;
  ppr_t              ppr_d;
  logic [CODE_W-1:0] auxb_d;
  logic              held_d;

  always_comb begin
    icr_d  = icr_q;
    ppr_d  = ppr_q;
    auxb_d = auxb_q;
    held_d = held_q;
    if (ld_icr)  icr_d  = payload[DIV_W-1:0];
    if (ld_ppr)  ppr_d  = ppr_t'(payload);
    if (ld_auxb) auxb_d = payload;
    if (op_crst)     held_d = 1'b1;
    else if (op_pon) held_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icr_q  <= '0;
      ppr_q  <= '0;
      auxb_q <= '0;
      held_q <= 1'b1;
      pon_q  <= 1'b0;
      crst_q <= 1'b0;
      fh_q   <= 1'b0;
    end else begin
      icr_q  <= icr_d;
      ppr_q  <= ppr_d;
      auxb_q <= auxb_d;
      held_q <= held_d;
      pon_q  <= op_pon;
      crst_q <= op_crst;
      fh_q   <= op_fh;
    end
  end

  // R9: a hidden register moves only on its own load strobe, whatever held does
  assert_icr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ld_icr) |-> $stable(icr_q));
  assert_ppr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ld_ppr) |-> $stable(ppr_q));
  assert_auxb_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ld_auxb) |-> $stable(auxb_q));
  // R2, R3: held state changes only on its commands
  assert_held_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held_q) |-> $past(op_crst));
  assert_held_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(held_q) |-> $past(op_pon));
  // R4: command strobes are mutually exclusive
  assert_pulse_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pon_q, crst_q, fh_q}));
endmodule

// File: rtl/aux_ppoll.sv
module aux_ppoll
  import aux_cmd_pkg::*;
#(
  parameter int LINES = 8
) (
  input  ppr_t             ppr,
  input  logic             held,
  input  logic             ppoll_req,
  input  logic             ist,
  output logic [LINES-1:0] resp
);
  logic respond;

  assign respond = ppoll_req && !ppr.unconf && !held && (ist == ppr.sense);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign resp[g] = respond && (ppr.line == 3'(g));
  end

  // R8: at most one line driven; never while unconfigured or held
  always_comb begin
    assert_resp_onehot_R8: assert ($onehot0(resp));
    assert_resp_quiet_R8: assert (!(ppr.unconf || held) || (resp == '0));
  end
endmodule

// File: rtl/aux_status.sv
module aux_status #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_en,
  input  logic [W-1:0] evt,
  output logic [W-1:0] stat_q
);
  logic [W-1:0] stat_d;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_comb begin
      if (rd_en) stat_d[g] = evt[g];
      else       stat_d[g] = stat_q[g] | evt[g];
    end

    // R10: an event on any edge, read or not, is kept
    assert_evt_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(evt[g]) |-> stat_q[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  // R10: without a read, bits never fall
  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en) |-> ((stat_q & $past(stat_q)) == $past(stat_q)));
endmodule

// File: rtl/aux_cmd_port.sv
module aux_cmd_port
  import aux_cmd_pkg::*;
#(
  parameter int STAT_W   = 8,
  parameter int PP_LINES = 8,
  parameter int DIV_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [7:0]          wr_data,
  input  logic                rd_en,
  input  logic [STAT_W-1:0]   evt_in,
  output logic [STAT_W-1:0]   rd_data,
  input  logic                ppoll_req,
  input  logic                local_ist,
  output logic                pon_pulse,
  output logic                crst_pulse,
  output logic                fh_pulse,
  output logic                held_reset,
  output logic [DIV_W-1:0]    clk_div,
  output logic                pp_unconf,
  output logic                pp_sense,
  output logic [2:0]          pp_line,
  output logic [4:0]          auxb,
  output logic                fast_src_hs,
  output logic [PP_LINES-1:0] pp_resp
);
  localparam int TRI_BIT = 2;

  logic              ld_icr, ld_ppr, ld_auxb, op_pon, op_crst, op_fh;
  logic [CODE_W-1:0] payload;
  ppr_t              ppr_q;

  aux_decode u_dec (
    .wr_en   (wr_en),
    .wr_byte (wr_data),
    .ld_icr  (ld_icr),
    .ld_ppr  (ld_ppr),
    .ld_auxb (ld_auxb),
    .op_pon  (op_pon),
    .op_crst (op_crst),
    .op_fh   (op_fh),
    .payload (payload)
  );

  aux_hidden_regs #(.DIV_W(DIV_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_icr  (ld_icr),
    .ld_ppr  (ld_ppr),
    .ld_auxb (ld_auxb),
    .op_pon  (op_pon),
    .op_crst (op_crst),
    .op_fh   (op_fh),
    .payload (payload),
    .icr_q   (clk_div),
    .ppr_q   (ppr_q),
    .auxb_q  (auxb),
    .held_q  (held_reset),
    .pon_q   (pon_pulse),
    .crst_q  (crst_pulse),
    .fh_q    (fh_pulse)
  );

  aux_ppoll #(.LINES(PP_LINES)) u_pp (
    .ppr       (ppr_q),
    .held      (held_reset),
    .ppoll_req (ppoll_req),
    .ist       (local_ist),
    .resp      (pp_resp)
  );

  aux_status #(.W(STAT_W)) u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_en  (rd_en),
    .evt    (evt_in),
    .stat_q (rd_data)
  );

  assign pp_unconf   = ppr_q.unconf;
  assign pp_sense    = ppr_q.sense;
  assign pp_line     = ppr_q.line;
  assign fast_src_hs = auxb[TRI_BIT];

  // R2, R3, R4: each strobe follows the matching write by one edge
  assert_crst_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    crst_pulse |-> $past(wr_en && wr_data == 8'h02));
  assert_pon_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pon_pulse |-> $past(wr_en && wr_data == 8'h00));
  assert_fh_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fh_pulse |-> $past(wr_en && wr_data == 8'h03));
  // R1: a write with an undefined control code leaves the divider alone
  assert_undef_noop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[7:5] == 3'b010) |=> $stable(clk_div));
endmodule

// File: tb/tb_aux_cmd_port.sv
`timescale 1ns/1ps
module tb_aux_cmd_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, rd_en, ppoll_req, local_ist;
  logic [7:0] wr_data, evt_in, rd_data, pp_resp;
  logic       pon_pulse, crst_pulse, fh_pulse, held_reset;
  logic [3:0] clk_div;
  logic       pp_unconf, pp_sense, fast_src_hs;
  logic [2:0] pp_line;
  logic [4:0] auxb;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference state
  logic       m_held, m_pon, m_crst, m_fh;
  logic [3:0] m_div;
  logic [4:0] m_ppr, m_auxb;
  logic [7:0] m_stat;

  always #4 clk = ~clk;

  aux_cmd_port dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .evt_in(evt_in), .rd_data(rd_data),
    .ppoll_req(ppoll_req), .local_ist(local_ist),
    .pon_pulse(pon_pulse), .crst_pulse(crst_pulse), .fh_pulse(fh_pulse),
    .held_reset(held_reset), .clk_div(clk_div), .pp_unconf(pp_unconf),
    .pp_sense(pp_sense), .pp_line(pp_line), .auxb(auxb),
    .fast_src_hs(fast_src_hs), .pp_resp(pp_resp)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R8 expected response
  function automatic logic [7:0] exp_resp(input logic req, input logic ist);
    if (req && !m_ppr[4] && !m_held && (ist == m_ppr[3]))
      return 8'(1) << m_ppr[2:0];
    return 8'h00;
  endfunction

  task automatic check_regs();
    chk("R2/R3 held", held_reset, m_held);
    chk("R3 pon", pon_pulse, m_pon);
    chk("R2 crst", crst_pulse, m_crst);
    chk("R4 fh", fh_pulse, m_fh);
    chk("R5 div", clk_div, m_div);
    chk("R6 ppr", {pp_unconf, pp_sense, pp_line}, m_ppr);
    chk("R7 auxb", auxb, m_auxb);
    chk("R7 fast", fast_src_hs, m_auxb[2]);
  endtask

  // one cycle: drive at negedge, check combinational, clock, check registered
  task automatic step(input logic we, input logic [7:0] d, input logic rd,
                      input logic [7:0] ev, input logic pr, input logic ist);
    wr_en = we; wr_data = d; rd_en = rd; evt_in = ev; ppoll_req = pr; local_ist = ist;
    #1;
    chk("R8 resp", pp_resp, exp_resp(pr, ist));
    chk("R10 rd_data", rd_data, m_stat);
    @(posedge clk);
    m_pon = 1'b0; m_crst = 1'b0; m_fh = 1'b0;
    if (we) begin
      case (d[7:5])
        3'b000: begin
          if (d[4:0] == 5'h00) begin m_pon = 1'b1; m_held = 1'b0; end
          if (d[4:0] == 5'h02) begin m_crst = 1'b1; m_held = 1'b1; end
          if (d[4:0] == 5'h03) m_fh = 1'b1;
        end
        3'b001: m_div = d[3:0];
        3'b011: m_ppr = d[4:0];
        3'b101: m_auxb = d[4:0];
        default: ;
      endcase
    end
    m_stat = rd ? ev : (m_stat | ev);
    @(negedge clk);
    check_regs();
  endtask

  task automatic wr(input logic [7:0] d);
    step(1'b1, d, 1'b0, 8'h00, 1'b0, 1'b0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int unsigned seed;
    seed = 32'd2024;
    void'($urandom(seed));
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; rd_en = 1'b0;
    evt_in = '0; ppoll_req = 1'b0; local_ist = 1'b0;
    m_held = 1'b1; m_pon = 0; m_crst = 0; m_fh = 0;
    m_div = '0; m_ppr = '0; m_auxb = '0; m_stat = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check_regs();
    chk("R11 stat", rd_data, 8'h00);
    chk("R11 resp", pp_resp, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: held blocks response even when configured
    step(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0);
    wr(8'h00);                       // R3 release
    chk("R3 released", held_reset, 1'b0);
    wr(8'h6D);                       // R6 U=0 S=1 line 5
    step(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1);  // R8 in phase -> line 5
    chk("R8 line5", pp_resp, 8'h20);
    step(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0);  // R8 sense mismatch
    wr(8'h62);                       // S=0 line 2
    step(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0);  // R8 inverted sense
    wr(8'h7A);                       // R8 U=1 -> quiet
    step(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0);
    wr(8'h3F);                       // R5 bit4 ignored -> F
    wr(8'hA4);                       // R7 TRI set
    wr(8'h4F); wr(8'h9F); wr(8'hC1); wr(8'hFF);  // R1 undefined codes
    wr(8'h01); wr(8'h1F);            // R4 unassigned immediates
    wr(8'h03);                       // R4 finish handshake
    wr(8'h02);                       // R2 chip reset
    chk("R9 div kept", clk_div, 4'hF);
    wr(8'h25);                       // R9 load while held
    wr(8'h00);
    chk("R9 div loaded", clk_div, 4'h5);
    // R10 status
    step(1'b0, 8'h00, 1'b0, 8'h81, 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b0, 8'h02, 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b1, 8'h10, 1'b0, 1'b0);  // read with event same edge
    chk("R10 survive", rd_data, 8'h10);
    step(1'b0, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0);

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] d;
      logic [2:0] cc;
      d = 8'($urandom());
      cc = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 3) != 0) d[7:5] = cc;
      if (d[7:5] == 3'b000 && $urandom_range(0, 1) == 1) d[4:0] = 5'($urandom_range(0, 3));
      step(1'($urandom_range(0, 1)), d, ($urandom_range(0, 3) == 0),
           8'($urandom()) & 8'($urandom()), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule